// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead-Time Insertion

This block sits between the two digital switching commands of a half-bridge (one for the upper switch, one for the lower switch) and the two gate-enable signals that go to the power stage. Each gate enable follows its own command in phase, so a high command asks for that switch to conduct. Between the commands and the gates, the block prevents shoot-through in two ways. It never lets both gates be on together, and it drives both gates off whenever both commands are high at once. After any gate turns off, it also holds off every turn-on until a programmable number of clock cycles has passed.

Two undervoltage flags, already digitised and with their hysteresis already applied, gate the outputs. The low-supply flag removes both gates. The floating-supply flag removes only the upper gate. When either flag clears, a fresh dead time runs before any gate may turn on. The commands and the flags are asynchronous to the block clock and pass through a two-flop synchroniser. Two status outputs show when a dead-time interval is running and when the two commands conflict.

The dead time is a cycle count, `DEAD_CYCLES`. A value of 32 at 100 MHz gives about 320 ns, and the count should be chosen to fall between 220 ns and 420 ns at the actual clock. The control path has ample margin for switching at 400 kHz.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: The synchronous active-low reset drives both gates low and starts a full dead time. After `rst_n` is sampled high, a command held high from reset turns its gate on at rising edge DEAD_CYCLES+1, and `dt_active` is low from edge DEAD_CYCLES onward.
- R2: Commands and undervoltage flags pass through a two-stage synchroniser. With no dead time pending, a gate turns on at the third rising edge that samples its command high.
- R3: Each gate is non-inverting with respect to its command. A gate that is on turns off at the third rising edge that samples its command low.
- R4: While both commands are high, `interlock_fault` is high (from the second edge that samples both high) and both gates are driven off (from the third edge).
- R5: When a gate turns off at edge t, `dt_active` is high after edges t through t+DEAD_CYCLES-1. No gate turns on before edge t+DEAD_CYCLES+1, even if its command is already active.
- R6: While the low-supply undervoltage flag `uv_vcc` is high, both gates are off, starting from the third edge that samples it high.
- R7: While only the floating-supply flag `uv_float` is high, the upper gate is off and the lower gate still follows its command.
- R8: When an undervoltage flag clears, the dead time restarts. A gate whose command is held high turns on at edge DEAD_CYCLES+4, counted from the first edge that samples the flag low.
- R9: If a command drops while its turn-on is waiting for a dead time to end, the turn-on is cancelled and the gate stays low for the whole interval.
- R10: Both gates are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cmd | input | 1 | Upper-switch command, asynchronous, high = conduct |
| lo_cmd | input | 1 | Lower-switch command, asynchronous, high = conduct |
| uv_vcc | input | 1 | Low-supply undervoltage flag, high = undervoltage |
| uv_float | input | 1 | Floating-supply undervoltage flag, high = undervoltage |
| hi_gate | output | 1 | Upper gate enable |
| lo_gate | output | 1 | Lower gate enable |
| dt_active | output | 1 | High while a dead-time interval is running |
| interlock_fault | output | 1 | High while both synchronised commands are high |

## Verification
The bench counts the exact edge at which the opposite gate rises after a handover. A counter that is one cycle short or long, or that lets a same-cycle turn-on slip past the reload, moves that edge. Conflicting commands are applied while one gate is already on, because a design that only blocked new turn-ons would leave the old gate on. A command is withdrawn in the middle of a dead time, which catches a latched turn-on request that would fire late. Each undervoltage flag is asserted and then released: a design that scoped the floating flag to both gates would drop the lower gate, and one without the restart would turn a gate on immediately after the flag clears.

// File: rtl/hb_pkg.sv
// Package: shared types for the half-bridge interlock.
// Assumes: one synchroniser vector carries all asynchronous inputs.
package hb_pkg;

    // Bit positions inside the synchronised input vector
    localparam int unsigned IN_HI  = 0;
    localparam int unsigned IN_LO  = 1;
    localparam int unsigned IN_UVC = 2;
    localparam int unsigned IN_UVF = 3;
    localparam int unsigned IN_W   = 4;

    typedef struct packed {
        logic uv_flt;
        logic uv_vcc;
        logic lo;
        logic hi;
    } hb_in_t;

endpackage

// File: rtl/hb_sync.sv
// Module: multi-stage flop synchroniser for a vector of asynchronous bits.
// Assumes: each bit is an independent level, with no coherence between bits;
// reset clears every stage.
module hb_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Shift one stage further along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/hb_dead_timer.sv
// Module: down-counter that measures the dead-time interval.
// Assumes: reload wins over counting; reset loads a full interval so that
// no gate can turn on right after reset.
module hb_dead_timer #(
    parameter int unsigned DEAD_CYCLES = 32,
    localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired,
    output logic running
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DEAD_CYCLES);

    logic [CNT_W-1:0] remain_q;

    // Load on reset or reload, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)               remain_q <= LOAD_VAL;
        else if (reload)          remain_q <= LOAD_VAL;
        else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);
    assign running = !expired;

endmodule

// File: rtl/hb_gate_ctrl.sv
// Module: gate decision logic. It applies the conflict interlock and the
// undervoltage masks, detects turn-off events and flag releases, and turns
// gates on only after the dead time has expired.
// Assumes: inputs are already synchronised; the timer's expired flag comes
// from a register, so there is no combinational loop through reload.
module hb_gate_ctrl
    import hb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  hb_in_t sin,
    input  logic   dt_expired,
    output logic   dt_reload,
    output logic   hi_gate,
    output logic   lo_gate,
    output logic   conflict
);

    logic hi_q, lo_q;
    logic uvc_prev_q, uvf_prev_q;
    logic want_hi, want_lo;
    logic turn_off, uv_release;
    logic hi_d, lo_d;

    // Requests after the interlock and the supply masks
    always_comb begin
        conflict = sin.hi & sin.lo;
        want_hi  = sin.hi & ~sin.lo & ~sin.uv_vcc & ~sin.uv_flt;
        want_lo  = sin.lo & ~sin.hi & ~sin.uv_vcc;
    end

    // Events that restart the dead time
    always_comb begin
        turn_off   = (hi_q & ~want_hi) | (lo_q & ~want_lo);
        uv_release = (uvc_prev_q & ~sin.uv_vcc) | (uvf_prev_q & ~sin.uv_flt);
        dt_reload  = turn_off | uv_release;
    end

    // Next gate state: turn off at once, turn on only when the path is clear
    always_comb begin
        hi_d = hi_q ? want_hi : (want_hi & dt_expired & ~lo_q & ~dt_reload);
        lo_d = lo_q ? want_lo : (want_lo & dt_expired & ~hi_q & ~dt_reload);
    end

    // Gate registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    // Previous flag levels, used to detect a release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uvc_prev_q <= 1'b0;
            uvf_prev_q <= 1'b0;
        end else begin
            uvc_prev_q <= sin.uv_vcc;
            uvf_prev_q <= sin.uv_flt;
        end
    end

    assign hi_gate = hi_q;
    assign lo_gate = lo_q;

endmodule

// File: rtl/hb_deadtime_ctrl.sv
// Module: top of the half-bridge interlock and dead-time controller.
// Assumes: commands and undervoltage flags are asynchronous levels; the
// flags already include their hysteresis; DEAD_CYCLES >= 1.
module hb_deadtime_ctrl
    import hb_pkg::*;
#(
    parameter int unsigned DEAD_CYCLES = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic uv_vcc,
    input  logic uv_float,
    output logic hi_gate,
    output logic lo_gate,
    output logic dt_active,
    output logic interlock_fault
);

    logic [IN_W-1:0] raw_vec;
    logic [IN_W-1:0] sync_vec;
    hb_in_t          sin;
    logic            reload, expired;

    // Pack the asynchronous inputs into the synchroniser vector
    always_comb begin
        raw_vec         = '0;
        raw_vec[IN_HI]  = hi_cmd;
        raw_vec[IN_LO]  = lo_cmd;
        raw_vec[IN_UVC] = uv_vcc;
        raw_vec[IN_UVF] = uv_float;
    end

    hb_sync #(
        .WIDTH  (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (sync_vec)
    );

    // Unpack the synchronised vector into named fields
    always_comb begin
        sin.hi     = sync_vec[IN_HI];
        sin.lo     = sync_vec[IN_LO];
        sin.uv_vcc = sync_vec[IN_UVC];
        sin.uv_flt = sync_vec[IN_UVF];
    end

    hb_dead_timer #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .expired (expired),
        .running (dt_active)
    );

    hb_gate_ctrl u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sin        (sin),
        .dt_expired (expired),
        .dt_reload  (reload),
        .hi_gate    (hi_gate),
        .lo_gate    (lo_gate),
        .conflict   (interlock_fault)
    );

endmodule

// File: rtl/hb_checker.sv
// Module: property checker attached to the controller with bind.
// Assumes: a fixed synchroniser depth of two, so the raw flags reach the
// gates three edges after they are sampled.
module hb_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_vcc,
    input logic uv_float,
    input logic hi_gate,
    input logic lo_gate,
    input logic dt_active,
    input logic interlock_fault
);

    assert_never_both_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    assert_conflict_clears_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        interlock_fault |=> (!hi_gate && !lo_gate));

    assert_lo_on_after_deadtime_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_gate) |-> $past(!dt_active));

    assert_hi_on_after_deadtime_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_gate) |-> $past(!dt_active));

    assert_vcc_uv_blocks_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_vcc, 3) |-> (!hi_gate && !lo_gate));

    assert_float_uv_blocks_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_float, 3) |-> !hi_gate);

endmodule

bind hb_deadtime_ctrl hb_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .uv_vcc          (uv_vcc),
    .uv_float        (uv_float),
    .hi_gate         (hi_gate),
    .lo_gate         (lo_gate),
    .dt_active       (dt_active),
    .interlock_fault (interlock_fault)
);

// File: tb/tb_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module tb_hb_deadtime_ctrl;

    localparam int D = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, uv_vcc = 1'b0, uv_float = 1'b0;
    logic hi_gate, lo_gate, dt_active, interlock_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_deadtime_ctrl #(.DEAD_CYCLES(D), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .uv_vcc(uv_vcc), .uv_float(uv_float), .hi_gate(hi_gate),
        .lo_gate(lo_gate), .dt_active(dt_active), .interlock_fault(interlock_fault)
    );

    // Reference model state: two sync stages, previous flags, gates, counter
    logic [3:0] m_s1 = '0, m_s2 = '0;
    logic [1:0] m_uvp = '0;
    logic       m_hi = 1'b0, m_lo = 1'b0;
    int         m_cnt = D;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected next state from the requirements (bit0 hi, bit1 lo, bit2 uv_vcc, bit3 uv_float)
    task automatic model_step();
        logic w_hi, w_lo, rel, off, n_hi, n_lo;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_uvp = '0; m_hi = 0; m_lo = 0; m_cnt = D;
            return;
        end
        w_hi = m_s2[0] & ~m_s2[1] & ~m_s2[2] & ~m_s2[3];
        w_lo = m_s2[1] & ~m_s2[0] & ~m_s2[2];
        off  = (m_hi & ~w_hi) | (m_lo & ~w_lo);
        rel  = (m_uvp[0] & ~m_s2[2]) | (m_uvp[1] & ~m_s2[3]) | off;
        n_hi = m_hi ? w_hi : (w_hi & (m_cnt == 0) & ~m_lo & ~rel);
        n_lo = m_lo ? w_lo : (w_lo & (m_cnt == 0) & ~m_hi & ~rel);
        m_cnt = rel ? D : ((m_cnt != 0) ? m_cnt - 1 : 0);
        m_uvp = {m_s2[3], m_s2[2]};
        m_s2  = m_s1;
        m_s1  = {uv_float, uv_vcc, lo_cmd, hi_cmd};
        m_hi  = n_hi;
        m_lo  = n_lo;
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 hi_gate model", hi_gate, m_hi);
        check("R3 lo_gate model", lo_gate, m_lo);
        check("R5 dt_active model", dt_active, m_cnt != 0);
        check("R4 interlock_fault model", interlock_fault, m_s2[0] & m_s2[1]);
        check("R10 exclusive gates", hi_gate & lo_gate, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        bit ok;
        void'($urandom(32'd4711));
        // R1: reset state, then first turn-on after a full dead time
        hi_cmd = 1;
        ticks(3);
        check("R1 reset hi_gate", hi_gate, 1'b0);
        check("R1 reset lo_gate", lo_gate, 1'b0);
        check("R1 reset dt_active", dt_active, 1'b1);
        rst_n = 1;
        ticks(D);
        check("R1 hi still off at edge D", hi_gate, 1'b0);
        check("R1 dead time over at edge D", dt_active, 1'b0);
        tick();
        check("R1 R2 hi on at edge D+1", hi_gate, 1'b1);

        // R3 R5: handover from upper to lower switch
        hi_cmd = 0; lo_cmd = 1;
        ticks(2);
        check("R3 hi still on before third edge", hi_gate, 1'b1);
        tick();
        check("R3 hi off at third edge", hi_gate, 1'b0);
        check("R5 dead time starts", dt_active, 1'b1);
        ticks(D - 1);
        check("R5 lo held during dead time", lo_gate, 1'b0);
        check("R5 dt still active", dt_active, 1'b1);
        tick();
        check("R5 lo held at dt end", lo_gate, 1'b0);
        tick();
        check("R5 lo on at t+D+1", lo_gate, 1'b1);

        // R4: conflicting commands while lower gate is on
        hi_cmd = 1;
        ticks(2);
        check("R4 fault flagged", interlock_fault, 1'b1);
        tick();
        check("R4 lo forced off", lo_gate, 1'b0);
        check("R4 hi kept off", hi_gate, 1'b0);

        // R9: pending lower turn-on cancelled inside the dead time
        hi_cmd = 0;
        ticks(5);
        lo_cmd = 0;
        ok = 1;
        for (int i = 0; i < D + 10; i++) begin
            tick();
            if (lo_gate || hi_gate) ok = 0;
        end
        check("R9 cancelled turn-on stays low", ok, 1'b1);

        // R6 R8: low-supply flag removes both gates and restarts the dead time
        lo_cmd = 1;
        ticks(D + 5);
        check("R2 lo on before uv", lo_gate, 1'b1);
        uv_vcc = 1;
        ticks(3);
        check("R6 lo off under uv_vcc", lo_gate, 1'b0);
        ticks(10);
        check("R6 lo stays off under uv_vcc", lo_gate, 1'b0);
        uv_vcc = 0;
        ticks(D + 3);
        check("R8 lo held after uv release", lo_gate, 1'b0);
        tick();
        check("R8 lo on at D+4 after release", lo_gate, 1'b1);

        // R7 R8: floating flag only affects the upper gate
        uv_float = 1;
        ticks(5);
        check("R7 lo unaffected by uv_float", lo_gate, 1'b1);
        hi_cmd = 1; lo_cmd = 0;
        ticks(D + 10);
        check("R7 hi blocked by uv_float", hi_gate, 1'b0);
        uv_float = 0;
        ticks(D + 3);
        check("R8 hi held after float release", hi_gate, 1'b0);
        tick();
        check("R8 hi on at D+4 after release", hi_gate, 1'b1);

        // Random phase: long and short command patterns, rare flags and resets
        for (int seg = 0; seg < 120; seg++) begin
            int r = $urandom_range(0, 99);
            hi_cmd   = (r < 45) || (r >= 90);
            lo_cmd   = (r >= 40) && (r < 88);
            uv_vcc   = ($urandom_range(0, 19) == 0);
            uv_float = ($urandom_range(0, 14) == 0);
            rst_n    = ($urandom_range(0, 59) != 0);
            ticks($urandom_range(1, 70));
            rst_n = 1;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule